// File: doc/BRIEF.md
# Memory-type range register bank

This block keeps the memory-type configuration of one processor context: eleven fixed-range registers, one default-type register, one page-attribute register and `NUM_PAIRS` pairs of variable base and mask registers. Software reaches them through a 12-bit register index and a 64-bit data bus. Every write is checked against the rules of the class of register it targets. A legal write commits at the clock edge. An illegal write is dropped, and the block raises a one-cycle error pulse. Reads return the stored value one cycle after the request. A read of the capability index returns a constant word.

The stored state is also exported without delay to a downstream memory-type resolver. The fixed-range registers appear as a packed array of 88 type bytes. The enables and the default type come out as separate fields, and the attribute, base and mask registers come out in full.

Top module: `memtype_regbank`

## Requirements
- R1: After reset every register reads zero except the page-attribute register, which holds 0x0007040600070406; `rdata` and `err` are zero.
- R2: A range memory type is legal only for the codes 0, 1, 4, 5 and 6. A write to a fixed-range index is accepted only when all eight bytes hold legal range types.
- R3: A write to the page-attribute index (0x277) is accepted only when each of its eight bytes is one of 0, 1, 4, 5, 6 or 7.
- R4: A write to the default-type index (0x2FF) is rejected if any bit outside 0xCFF is set, or if bits 7:0 are not a legal range type. Stored bit 11 drives `map_en`, bit 10 drives `fixed_en`, and bits 7:0 drive `dflt_type`.
- R5: Index 0x200+2p selects base register p, for p < `NUM_PAIRS`. A base write needs a legal range type in bits 7:0, bits 11:8 clear, and every bit at or above `PA_WIDTH` clear.
- R6: Index 0x200+2p+1 selects mask register p. A mask write needs bits 10:0 clear and every bit at or above `PA_WIDTH` clear.
- R7: The fixed-range indices are 0x250, 0x258, 0x259 and 0x268 to 0x26F, in that order, and they are numbered unit 0 to unit 10. Byte k of unit u's data lands at array entry u*8+k, which is bits (u*8+k)*8+7 down to (u*8+k)*8 of `fixed_types`.
- R8: A read of index 0x0FE returns 0x500 OR `NUM_PAIRS`. A write to 0x0FE is rejected with `err`.
- R9: A read of an unrecognised index returns zero and raises `err`. A write to an unrecognised index raises `err` and changes nothing.
- R10: `rdata` and `err` are registered. They reflect a request in the cycle after it, `err` lasts exactly one cycle per faulting request, and `rdata` holds its value across writes and idle cycles.
- R11: A rejected write leaves every stored register, and so every exported field, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| idx | input | 12 | Register index |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, one cycle after `rd_en` |
| err | output | 1 | One-cycle fault for a rejected write or an unknown read |
| map_en | output | 1 | Global memory-type enable (default-type bit 11) |
| fixed_en | output | 1 | Fixed-range enable (default-type bit 10) |
| dflt_type | output | 8 | Default memory type |
| attr_cfg | output | 64 | Page-attribute register |
| fixed_types | output | 704 | 88 fixed-range type bytes, entry e at bits 8e+7:8e |
| var_base | output | 64*NUM_PAIRS | Base registers, pair p at bits 64p+63:64p |
| var_mask | output | 64*NUM_PAIRS | Mask registers, pair p at bits 64p+63:64p |

## Verification
The assertions take it for granted that `wr_en` and `rd_en` are never high in the same cycle, and that `idx` and `wdata` are valid whenever either is high. One assertion states the first of these as an input rule. The stimulus issues a single request at a time and follows each with an idle cycle, so the check that a fault pulse lasts one cycle and the hold of `rdata` across writes can be seen without overlap. Values are swept byte by byte and bit by bit against a small configuration with four pairs and a 36-bit address width. That configuration puts the address-width boundary well inside the 64-bit word, so bits on both sides of the boundary are exercised.

// File: rtl/memtype_pkg.sv
`timescale 1ns/1ps
package memtype_pkg;
   localparam int unsigned IDX_W       = 12;
   localparam int unsigned FIX_UNITS   = 11;
   localparam int unsigned FIX_ENTRIES = FIX_UNITS * 8;
   localparam int unsigned FIX_BITS    = FIX_ENTRIES * 8;
   localparam int unsigned UNIT_W      = 4;

   localparam logic [IDX_W-1:0] IDX_CAP   = 12'h0FE;
   localparam logic [IDX_W-1:0] IDX_VAR0  = 12'h200;
   localparam logic [IDX_W-1:0] IDX_FIX64 = 12'h250;
   localparam logic [IDX_W-1:0] IDX_FIX16 = 12'h258;
   localparam logic [IDX_W-1:0] IDX_FIX4  = 12'h268;
   localparam logic [IDX_W-1:0] IDX_ATTR  = 12'h277;
   localparam logic [IDX_W-1:0] IDX_DFLT  = 12'h2FF;

   localparam logic [63:0] ATTR_RESET = 64'h0007_0406_0007_0406;
   localparam logic [63:0] DFLT_KEEP  = 64'h0000_0000_0000_0CFF;
   localparam logic [63:0] CAP_BASE   = 64'h0000_0000_0000_0500;

   typedef enum logic [2:0] {
      CLS_NONE,
      CLS_CAP,
      CLS_DFLT,
      CLS_ATTR,
      CLS_FIX,
      CLS_VBASE,
      CLS_VMASK
   } reg_class_e;

   function automatic logic range_type_ok(input logic [7:0] t);
      return (t == 8'd0) || (t == 8'd1) || (t == 8'd4) || (t == 8'd5) || (t == 8'd6);
   endfunction

   function automatic logic attr_type_ok(input logic [7:0] t);
      return (t == 8'd0) || (t == 8'd1) || ((t >= 8'd4) && (t <= 8'd7));
   endfunction
endpackage

// File: rtl/memtype_decode.sv
`timescale 1ns/1ps
module memtype_decode
   import memtype_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 8,
   parameter int unsigned PAIR_W    = 3
) (
   input  logic [IDX_W-1:0]  idx,
   output reg_class_e        cls,
   output logic [UNIT_W-1:0] unit,
   output logic [PAIR_W-1:0] pair
);
   localparam logic [IDX_W-1:0] VAR_END = IDX_VAR0 + IDX_W'(2 * NUM_PAIRS);

   logic [IDX_W-1:0] var_off;
   assign var_off = idx - IDX_VAR0;

   always_comb begin
      cls  = CLS_NONE;
      unit = '0;
      pair = '0;
      if (idx == IDX_CAP) begin
         cls = CLS_CAP;
      end else if (idx == IDX_DFLT) begin
         cls = CLS_DFLT;
      end else if (idx == IDX_ATTR) begin
         cls = CLS_ATTR;
      end else if (idx == IDX_FIX64) begin
         cls  = CLS_FIX;
         unit = 4'd0;
      end else if ((idx == IDX_FIX16) || (idx == IDX_FIX16 + 12'd1)) begin
         cls  = CLS_FIX;
         unit = 4'd1 + {3'b000, idx[0]};
      end else if ((idx >= IDX_FIX4) && (idx <= IDX_FIX4 + 12'd7)) begin
         cls  = CLS_FIX;
         unit = 4'd3 + {1'b0, idx[2:0]};
      end else if ((idx >= IDX_VAR0) && (idx < VAR_END)) begin
         cls  = var_off[0] ? CLS_VMASK : CLS_VBASE;
         pair = var_off[PAIR_W:1];
      end
   end

   // R7: decoded fixed unit never exceeds the last unit
   always_comb begin
      a_r7_unit_range: assert (!(cls == CLS_FIX) || (unit < UNIT_W'(FIX_UNITS)));
   end
endmodule

// File: rtl/memtype_check.sv
`timescale 1ns/1ps
module memtype_check
   import memtype_pkg::*;
#(
   parameter int unsigned PA_WIDTH = 40
) (
   input  reg_class_e  cls,
   input  logic [63:0] wdata,
   output logic        legal
);
   localparam logic [63:0] HI_MASK = ~((64'd1 << PA_WIDTH) - 64'd1);

   logic [7:0] lane_rng_ok;
   logic [7:0] lane_attr_ok;

   for (genvar g = 0; g < 8; g++) begin : g_lane
      assign lane_rng_ok[g]  = range_type_ok(wdata[g*8 +: 8]);
      assign lane_attr_ok[g] = attr_type_ok(wdata[g*8 +: 8]);
   end

   logic hi_clear;
   assign hi_clear = ((wdata & HI_MASK) == 64'd0);

   always_comb begin
      unique case (cls)
         CLS_FIX:   legal = &lane_rng_ok;
         CLS_ATTR:  legal = &lane_attr_ok;
         CLS_DFLT:  legal = ((wdata & ~DFLT_KEEP) == 64'd0) && lane_rng_ok[0];
         CLS_VBASE: legal = lane_rng_ok[0] && (wdata[11:8] == 4'd0) && hi_clear;
         CLS_VMASK: legal = (wdata[10:0] == 11'd0) && hi_clear;
         default:   legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/memtype_store.sv
`timescale 1ns/1ps
module memtype_store
   import memtype_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 8,
   parameter int unsigned PAIR_W    = 3,
   parameter int unsigned PA_WIDTH  = 40
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    commit,
   input  reg_class_e              cls,
   input  logic [UNIT_W-1:0]       unit,
   input  logic [PAIR_W-1:0]       pair,
   input  logic [63:0]             wdata,
   output logic [FIX_BITS-1:0]     fix_flat,
   output logic [63:0]             dflt_q,
   output logic [63:0]             attr_q,
   output logic [NUM_PAIRS*64-1:0] base_flat,
   output logic [NUM_PAIRS*64-1:0] mask_flat
);
   localparam logic [63:0] HI_MASK = ~((64'd1 << PA_WIDTH) - 64'd1);

   for (genvar u = 0; u < FIX_UNITS; u++) begin : g_fix
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fix_flat[u*64 +: 64] <= '0;
         end else if (commit && (cls == CLS_FIX) && (unit == UNIT_W'(u))) begin
            fix_flat[u*64 +: 64] <= wdata;
         end
      end
   end

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_flat[p*64 +: 64] <= '0;
            mask_flat[p*64 +: 64] <= '0;
         end else if (commit && (pair == PAIR_W'(p))) begin
            if (cls == CLS_VBASE) base_flat[p*64 +: 64] <= wdata;
            if (cls == CLS_VMASK) mask_flat[p*64 +: 64] <= wdata;
         end
      end

      // R5: stored base keeps reserved and out-of-width bits clear
      a_r5_base_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
         ((base_flat[p*64 +: 64] & HI_MASK) == 64'd0) && (base_flat[p*64+8 +: 4] == 4'd0));
      // R6: stored mask keeps low and out-of-width bits clear
      a_r6_mask_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
         ((mask_flat[p*64 +: 64] & HI_MASK) == 64'd0) && (mask_flat[p*64 +: 11] == 11'd0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dflt_q <= '0;
         attr_q <= ATTR_RESET;
      end else if (commit) begin
         if (cls == CLS_DFLT) dflt_q <= wdata;
         if (cls == CLS_ATTR) attr_q <= wdata;
      end
   end

   // R4: stored default register never holds reserved bits
   a_r4_dflt_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (dflt_q & ~DFLT_KEEP) == 64'd0);

   for (genvar g = 0; g < 8; g++) begin : g_attr_chk
      // R3: every stored attribute byte is a legal encoding
      a_r3_attr_lane_legal: assert property (@(posedge clk) disable iff (!rst_n)
         attr_type_ok(attr_q[g*8 +: 8]));
   end
endmodule

// File: rtl/memtype_regbank.sv
`timescale 1ns/1ps
module memtype_regbank
   import memtype_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 8,
   parameter int unsigned PA_WIDTH  = 40
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [11:0]             idx,
   input  logic [63:0]             wdata,
   output logic [63:0]             rdata,
   output logic                    err,
   output logic                    map_en,
   output logic                    fixed_en,
   output logic [7:0]              dflt_type,
   output logic [63:0]             attr_cfg,
   output logic [703:0]            fixed_types,
   output logic [NUM_PAIRS*64-1:0] var_base,
   output logic [NUM_PAIRS*64-1:0] var_mask
);
   localparam int unsigned PAIR_W   = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
   localparam logic [63:0] CAP_WORD = CAP_BASE | 64'(NUM_PAIRS);

   if ((NUM_PAIRS < 1) || (NUM_PAIRS > 32)) begin : g_bad_pairs
      $error("NUM_PAIRS must lie in 1..32 so variable indices stay below the fixed block");
   end
   if ((PA_WIDTH < 13) || (PA_WIDTH > 63)) begin : g_bad_pa
      $error("PA_WIDTH must lie in 13..63");
   end
   if (FIX_BITS != 704) begin : g_bad_fix
      $error("fixed-range array width does not match the port");
   end

   reg_class_e          cls;
   logic [UNIT_W-1:0]   unit;
   logic [PAIR_W-1:0]   pair;
   logic                wr_ok;
   logic                commit;
   logic [63:0]         dflt_q;
   logic [63:0]         rd_val;
   logic                rd_known;

   memtype_decode #(.NUM_PAIRS(NUM_PAIRS), .PAIR_W(PAIR_W)) i_decode (
      .idx  (idx),
      .cls  (cls),
      .unit (unit),
      .pair (pair)
   );

   memtype_check #(.PA_WIDTH(PA_WIDTH)) i_check (
      .cls   (cls),
      .wdata (wdata),
      .legal (wr_ok)
   );

   assign commit = wr_en && wr_ok;

   memtype_store #(.NUM_PAIRS(NUM_PAIRS), .PAIR_W(PAIR_W), .PA_WIDTH(PA_WIDTH)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .cls       (cls),
      .unit      (unit),
      .pair      (pair),
      .wdata     (wdata),
      .fix_flat  (fixed_types),
      .dflt_q    (dflt_q),
      .attr_q    (attr_cfg),
      .base_flat (var_base),
      .mask_flat (var_mask)
   );

   assign map_en    = dflt_q[11];
   assign fixed_en  = dflt_q[10];
   assign dflt_type = dflt_q[7:0];

   always_comb begin
      rd_known = 1'b1;
      unique case (cls)
         CLS_CAP:   rd_val = CAP_WORD;
         CLS_DFLT:  rd_val = dflt_q;
         CLS_ATTR:  rd_val = attr_cfg;
         CLS_FIX:   rd_val = fixed_types[int'(unit)*64 +: 64];
         CLS_VBASE: rd_val = var_base[int'(pair)*64 +: 64];
         CLS_VMASK: rd_val = var_mask[int'(pair)*64 +: 64];
         default: begin
            rd_val   = 64'd0;
            rd_known = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         err <= (wr_en && !wr_ok) || (rd_en && !rd_known);
         if (rd_en) rdata <= rd_val;
      end
   end

   // R10: input rule, one request per cycle
   a_r10_single_request: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));
   // R10: no request, no fault in the next cycle
   a_r10_quiet_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en || rd_en) |=> !err);
   // R10: rdata only moves after a read
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
   // R11: rejected write leaves exported state alone
   a_r11_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ok) |=> ($stable(fixed_types) && $stable(attr_cfg) && $stable(var_base)
                             && $stable(var_mask) && $stable(dflt_type) && $stable(map_en)
                             && $stable(fixed_en) && err));
   // R2: accepted write does not fault
   a_r2_accept_no_err: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ok) |=> !err);
   // R8: capability read returns the constant word
   a_r8_cap_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (idx == IDX_CAP)) |=> (rdata == CAP_WORD) && !err);
   // R9: unknown read returns zero with a fault
   a_r9_unknown_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (cls == CLS_NONE)) |=> (rdata == 64'd0) && err);
endmodule

// File: tb/test_memtype_regbank.sv
`timescale 1ns/1ps
module test_memtype_regbank;
   localparam int NP = 4;
   localparam int PA = 36;
   localparam logic [63:0] HI = ~((64'd1 << PA) - 64'd1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [11:0]       idx = '0;
   logic [63:0]       wdata = '0;
   logic [63:0]       rdata;
   logic              err;
   logic              map_en;
   logic              fixed_en;
   logic [7:0]        dflt_type;
   logic [63:0]       attr_cfg;
   logic [703:0]      fixed_types;
   logic [NP*64-1:0]  var_base;
   logic [NP*64-1:0]  var_mask;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [63:0] m_fix [11];
   logic [63:0] m_dflt;
   logic [63:0] m_attr;
   logic [63:0] m_base [NP];
   logic [63:0] m_mask [NP];

   always #4 clk = ~clk;

   memtype_regbank #(.NUM_PAIRS(NP), .PA_WIDTH(PA)) i_memtype_regbank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx), .wdata(wdata),
      .rdata(rdata), .err(err), .map_en(map_en), .fixed_en(fixed_en), .dflt_type(dflt_type),
      .attr_cfg(attr_cfg), .fixed_types(fixed_types), .var_base(var_base), .var_mask(var_mask)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // unit numbering for fixed indices, -1 when not fixed
   function automatic int fix_unit(input logic [11:0] i);
      if (i == 12'h250) return 0;
      if (i == 12'h258) return 1;
      if (i == 12'h259) return 2;
      if (i >= 12'h268 && i <= 12'h26F) return 3 + int'(i - 12'h268);
      return -1;
   endfunction

   // 0 unknown, 1 cap, 2 default, 3 attribute, 4 fixed, 5 base, 6 mask
   function automatic int kind_of(input logic [11:0] i);
      if (i == 12'h0FE) return 1;
      if (i == 12'h2FF) return 2;
      if (i == 12'h277) return 3;
      if (fix_unit(i) >= 0) return 4;
      if (i >= 12'h200 && i < 12'h200 + 12'(2*NP)) return i[0] ? 6 : 5;
      return 0;
   endfunction

   function automatic bit rng_ok(input logic [7:0] t);
      return t inside {8'd0, 8'd1, 8'd4, 8'd5, 8'd6};
   endfunction

   function automatic bit att_ok(input logic [7:0] t);
      return t inside {8'd0, 8'd1, 8'd4, 8'd5, 8'd6, 8'd7};
   endfunction

   function automatic bit legal_of(input logic [11:0] i, input logic [63:0] d);
      bit ok;
      case (kind_of(i))
         2: return ((d & ~64'hCFF) == 0) && rng_ok(d[7:0]);
         3: begin
            ok = 1;
            for (int b = 0; b < 8; b++) ok &= att_ok(d[b*8 +: 8]);
            return ok;
         end
         4: begin
            ok = 1;
            for (int b = 0; b < 8; b++) ok &= rng_ok(d[b*8 +: 8]);
            return ok;
         end
         5: return rng_ok(d[7:0]) && (d[11:8] == 0) && ((d & HI) == 0);
         6: return (d[10:0] == 0) && ((d & HI) == 0);
         default: return 0;
      endcase
   endfunction

   function automatic logic [63:0] model_read(input logic [11:0] i);
      case (kind_of(i))
         1: return 64'h500 | 64'(NP);
         2: return m_dflt;
         3: return m_attr;
         4: return m_fix[fix_unit(i)];
         5: return m_base[(i - 12'h200) >> 1];
         6: return m_mask[(i - 12'h200) >> 1];
         default: return 64'd0;
      endcase
   endfunction

   task automatic cmp_state(input string req);
      chk(attr_cfg === m_attr, req, "attr_cfg", attr_cfg, m_attr);
      chk(map_en === m_dflt[11], req, "map_en", 64'(map_en), 64'(m_dflt[11]));
      chk(fixed_en === m_dflt[10], req, "fixed_en", 64'(fixed_en), 64'(m_dflt[10]));
      chk(dflt_type === m_dflt[7:0], req, "dflt_type", 64'(dflt_type), 64'(m_dflt[7:0]));
      for (int u = 0; u < 11; u++)
         chk(fixed_types[u*64 +: 64] === m_fix[u], req, "fixed unit", fixed_types[u*64 +: 64], m_fix[u]);
      for (int p = 0; p < NP; p++) begin
         chk(var_base[p*64 +: 64] === m_base[p], req, "var_base", var_base[p*64 +: 64], m_base[p]);
         chk(var_mask[p*64 +: 64] === m_mask[p], req, "var_mask", var_mask[p*64 +: 64], m_mask[p]);
      end
   endtask

   task automatic do_write(input logic [11:0] i, input logic [63:0] d, input string req);
      logic [63:0] rd_before;
      bit lg;
      rd_before = rdata;
      lg = legal_of(i, d);
      @(negedge clk);
      idx = i; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk(err === !lg, req, "write fault", 64'(err), 64'(!lg));
      if (lg) begin
         case (kind_of(i))
            2: m_dflt = d;
            3: m_attr = d;
            4: m_fix[fix_unit(i)] = d;
            5: m_base[(i - 12'h200) >> 1] = d;
            6: m_mask[(i - 12'h200) >> 1] = d;
            default: ;
         endcase
      end
      cmp_state(req);
      chk(rdata === rd_before, "R10", "rdata hold over write", rdata, rd_before);
      @(negedge clk);
      chk(err === 1'b0, "R10", "fault lasts one cycle", 64'(err), 64'd0);
   endtask

   task automatic do_read(input logic [11:0] i, input string req);
      logic [63:0] ev;
      bit ee;
      ev = model_read(i);
      ee = (kind_of(i) == 0);
      @(negedge clk);
      idx = i; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(rdata === ev, req, "read data", rdata, ev);
      chk(err === ee, req, "read fault", 64'(err), 64'(ee));
      @(negedge clk);
      chk(err === 1'b0, "R10", "fault lasts one cycle", 64'(err), 64'd0);
      chk(rdata === ev, "R10", "rdata hold idle", rdata, ev);
   endtask

   initial begin
      #(64'd8 * 64'd200000);
      if (!done) begin
         n_fail++;
         $display("FAIL R10 watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      logic [11:0] fidx [11];
      fidx[0] = 12'h250; fidx[1] = 12'h258; fidx[2] = 12'h259;
      for (int k = 0; k < 8; k++) fidx[3+k] = 12'h268 + 12'(k);
      for (int u = 0; u < 11; u++) m_fix[u] = '0;
      for (int p = 0; p < NP; p++) begin m_base[p] = '0; m_mask[p] = '0; end
      m_dflt = '0;
      m_attr = 64'h0007040600070406;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      chk(rdata === 64'd0, "R1", "rdata after reset", rdata, 64'd0);
      chk(err === 1'b0, "R1", "err after reset", 64'(err), 64'd0);
      cmp_state("R1");
      do_read(12'h277, "R1");

      // R2: one byte swept through every code, fillers legal
      for (int v = 0; v < 256; v++) begin
         d = 64'h0606060606060606;
         d[(v % 8)*8 +: 8] = 8'(v);
         do_write(fidx[v % 11], d, "R2");
      end

      // R3: attribute byte sweep
      for (int v = 0; v < 256; v++) begin
         d = 64'h0707070707070707;
         d[((v + 3) % 8)*8 +: 8] = 8'(v);
         do_write(12'h277, d, "R3");
      end
      do_read(12'h277, "R3");

      // R4: type byte sweep with both enables, then single stray bits
      for (int v = 0; v < 256; v++) do_write(12'h2FF, 64'hC00 | 64'(v), "R4");
      for (int b = 8; b < 64; b++) do_write(12'h2FF, 64'h5 | (64'd1 << b), "R4");
      do_read(12'h2FF, "R4");

      // R5, R6: bit walks on every pair
      for (int p = 0; p < NP; p++) begin
         for (int b = 0; b < 64; b++)
            do_write(12'h200 + 12'(2*p), 64'h6 | (64'd1 << b), "R5");
         for (int b = 0; b < 64; b++)
            do_write(12'h201 + 12'(2*p), 64'h800 | (64'd1 << b), "R6");
         do_write(12'h201 + 12'(2*p), ((64'd1 << PA) - 1) & ~64'h7FF, "R6");
         do_write(12'h200 + 12'(2*p), 64'h0000_000F_FFFF_F004 - 64'(p), "R5");
         do_read(12'h200 + 12'(2*p), "R5");
         do_read(12'h201 + 12'(2*p), "R6");
      end

      // R7: distinct legal bytes per unit, checked entry by entry
      for (int u = 0; u < 11; u++) begin
         d = '0;
         for (int k = 0; k < 8; k++) begin
            case ((u + k) % 5)
               0: d[k*8 +: 8] = 8'd0;
               1: d[k*8 +: 8] = 8'd1;
               2: d[k*8 +: 8] = 8'd4;
               3: d[k*8 +: 8] = 8'd5;
               default: d[k*8 +: 8] = 8'd6;
            endcase
         end
         do_write(fidx[u], d, "R7");
      end
      for (int e = 0; e < 88; e++)
         chk(fixed_types[e*8 +: 8] === m_fix[e/8][(e%8)*8 +: 8], "R7", "fixed entry",
             64'(fixed_types[e*8 +: 8]), 64'(m_fix[e/8][(e%8)*8 +: 8]));
      for (int u = 0; u < 11; u++) do_read(fidx[u], "R7");

      // R8: capability read, rejected write
      do_read(12'h0FE, "R8");
      do_write(12'h0FE, 64'h0, "R8");
      do_read(12'h0FE, "R8");

      // R11: illegal writes to every class leave state intact
      do_write(12'h277, 64'h0202020202020202, "R11");
      do_write(12'h2FF, 64'h1000, "R11");
      do_write(12'h26F, 64'h0707070707070707, "R11");
      do_write(12'h200, 64'h100, "R11");
      do_write(12'h201, 64'h1, "R11");

      // R9: every index read, then unknown-index writes
      for (int i = 0; i < 4096; i++) do_read(12'(i), "R9");
      for (int i = 0; i < 4096; i++)
         if (kind_of(12'(i)) == 0) do_write(12'(i), 64'h0606060606060606, "R9");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule